// File: doc/BRIEF.md
# Run-length sample stream expander

The expander turns a stream of compressed capture words into a plain stream of logic samples, one per output beat. Each compressed word is either a data word or a length word. A data word carries the levels of every channel and two control flags: one flag makes the base run two samples long instead of one, and the other says the next input word holds an extra repeat count. A length word contributes twice its value to the run started by the data word before it. The expander then emits the held channel levels once for each sample of the run.

Both sides use a valid/ready handshake. While a run is being emitted the input is held off, so the upstream source only needs to present the next word when the expander asks for it. A programmable sample limit ends output early, even in the middle of a run. An end-of-input marker on the final input word flags the final sample of the capture. In both cases the sample that ends the stream carries a last marker, and a done flag stays high until a synchronous clear prepares the block for the next capture.

Top module: `rle_expander`

## Requirements
- R1: The output sample equals bits 33:0 of the most recent data word, for every sample of the run that word starts.
- R2: A data word with bit 35 low emits one sample when its bit 34 is low and two samples when its bit 34 is high.
- R3: A data word with bit 35 high makes the next input word a length word; the run becomes (1 + bit 34) + 2 × (length word value), and the word after that is decoded as a data word again.
- R4: in_ready is low whenever out_valid is high, the next input word is taken only after the final sample of the run has been accepted downstream, and a stalled output sample holds its value.
- R5: With a non-zero limit, output stops after exactly limit samples since the last clear, even mid-run; the sample that reaches the limit has out_last high, and afterwards done is high while out_valid and in_ready are low.
- R6: A limit of zero means no limit: every sample of every run is emitted and done stays low without an end marker.
- R7: When in_end is high on an accepted input word, the final sample of the run that word completes has out_last high, and done is high afterwards; samples before it have out_last low.
- R8: clear returns the decoder to expecting a data word with a zero run count and a zero held sample (out_sample reads 0, out_valid low, in_ready high, done low) and restarts the limit count from zero.
- R9: A length word of all ones does not overflow the run count: the run lasts at least until a limit of a few dozen samples cuts it.
- R10: After reset out_valid, out_last and done are low, in_ready is high and out_sample is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Synchronous restart of decode state and sample count |
| limit | input | LIM_W (40) | Number of samples to emit before stopping; 0 means unlimited |
| in_valid | input | 1 | Input word present |
| in_word | input | CH_W+2 (36) | Compressed capture word |
| in_end | input | 1 | Marks the accepted word as the final input word |
| in_ready | output | 1 | Expander takes a word this cycle when in_valid is high |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the sample this cycle |
| out_sample | output | CH_W (34) | Channel levels of the current sample |
| out_last | output | 1 | Current sample ends the stream |
| done | output | 1 | Stream has ended; cleared by clear |

## Verification
A wrong run count shows as a sample stream of the wrong length at the ports: the following data word's levels appear one or more beats too early or too late, which a model comparison catches on the first beat after the faulty run. A wrong decode state, such as treating a length word as data, shows up as channel levels that never appeared in the data words, on the very next emitted sample. A sample counter that is not restarted by clear shows as a truncated stream that fails to stop at the limit, visible on the beat where out_last should rise. Backpressure faults show as overlapping in_ready and out_valid within the same cycle.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_LEN  = 2'd1,
    ST_EMIT = 2'd2,
    ST_HALT = 2'd3
  } dec_state_t;

endpackage

// File: rtl/rle_rst_sync.sv
module rle_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rle_limit.sv
module rle_limit #(
  parameter int LIM_W = 40
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             clear,
  input  logic             fire,
  input  logic [LIM_W-1:0] limit,
  output logic             hit
);

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear | fire;
    cnt_d  = cnt_q;
    if (clear)     cnt_d = '0;
    else if (fire) cnt_d = cnt_q + LIM_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = (limit != '0) && ((cnt_q + LIM_W'(1)) == limit);

  // R5: after the limiting beat the count equals the programmed limit
  p_count_at_limit_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (fire && hit && !clear) |=> (cnt_q == $past(limit)));

endmodule

// File: rtl/rle_decode.sv
module rle_decode
  import rle_pkg::*;
#(
  parameter int CH_W = 34
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [CH_W+1:0]   in_word,
  input  logic              in_end,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_sample,
  output logic              out_last,
  input  logic              hit_limit,
  output logic              fire,
  output logic              halted
);

  localparam int WORD_W = CH_W + 2;
  localparam int CNT_W  = WORD_W + 2;
  localparam int REP_B  = CH_W;
  localparam int LEN_B  = CH_W + 1;

  dec_state_t      state_q, state_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CH_W-1:0]  smp_q, smp_d;
  logic             end_q, end_d;
  logic             take, run_final, reg_en;

  always_comb begin
    in_ready  = (state_q == ST_DATA) || (state_q == ST_LEN);
    out_valid = (state_q == ST_EMIT);
    take      = in_valid && in_ready;
    fire      = out_valid && out_ready;
    run_final = (run_q == CNT_W'(1));
    out_last  = out_valid && (hit_limit || (run_final && end_q));
    halted    = (state_q == ST_HALT);
    reg_en    = clear | take | fire;
  end

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    smp_d   = smp_q;
    end_d   = end_q;
    if (clear) begin
      state_d = ST_DATA;
      run_d   = '0;
      smp_d   = '0;
      end_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_DATA: if (take) begin
          smp_d   = in_word[CH_W-1:0];
          run_d   = CNT_W'(1) + CNT_W'(in_word[REP_B]);
          end_d   = in_end;
          state_d = in_word[LEN_B] ? ST_LEN : ST_EMIT;
        end
        ST_LEN: if (take) begin
          run_d   = run_q + CNT_W'({in_word, 1'b0});
          end_d   = end_q | in_end;
          state_d = ST_EMIT;
        end
        ST_EMIT: if (fire) begin
          run_d = run_q - CNT_W'(1);
          if (out_last)       state_d = ST_HALT;
          else if (run_final) state_d = ST_DATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_DATA;
      run_q   <= '0;
      smp_q   <= '0;
      end_q   <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      run_q   <= run_d;
      smp_q   <= smp_d;
      end_q   <= end_d;
    end
  end

  assign out_sample = smp_q;

  // R4: a stalled sample keeps its value and stays offered
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_sample)));

  // R4: input is never offered while a run is being emitted
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> !in_ready);

  // R8: clear leaves an idle decoder with a zero sample
  p_clear_idle_r8: assert property (@(posedge clk) disable iff (!srst_n)
    clear |=> (in_ready && !out_valid && out_sample == '0 && !halted));

endmodule

// File: rtl/rle_expander.sv
module rle_expander #(
  parameter int CH_W  = 34,
  parameter int LIM_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [LIM_W-1:0]  limit,
  input  logic              in_valid,
  input  logic [CH_W+1:0]   in_word,
  input  logic              in_end,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_sample,
  output logic              out_last,
  output logic              done
);

  logic srst_n;
  logic fire, hit;

  rle_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rle_limit #(.LIM_W(LIM_W)) u_limit (
    .clk    (clk),
    .srst_n (srst_n),
    .clear  (clear),
    .fire   (fire),
    .limit  (limit),
    .hit    (hit)
  );

  rle_decode #(.CH_W(CH_W)) u_dec (
    .clk        (clk),
    .srst_n     (srst_n),
    .clear      (clear),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_end     (in_end),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .out_last   (out_last),
    .hit_limit  (hit),
    .fire       (fire),
    .halted     (done)
  );

  // R5 / R7: a last sample accepted downstream ends the stream
  p_last_ends_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && out_ready && out_last && !clear) |=> done);

  // R5: a finished stream offers nothing on either side
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (!out_valid && !in_ready));

endmodule

// File: tb/rle_expander_tb_top.sv
module rle_expander_tb_top;

  localparam int CH_W  = 34;
  localparam int WW    = CH_W + 2;
  localparam int LIM_W = 40;
  localparam int MAXW  = 256;
  localparam int MAXX  = 4096;

  logic             clk, rst_n, clear, in_valid, in_end, out_ready;
  logic [LIM_W-1:0] limit;
  logic [WW-1:0]    in_word;
  logic             in_ready, out_valid, out_last, done;
  logic [CH_W-1:0]  out_sample;

  rle_expander #(.CH_W(CH_W), .LIM_W(LIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .limit(limit),
    .in_valid(in_valid), .in_word(in_word), .in_end(in_end), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_last(out_last), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [WW-1:0]   wbuf [MAXW];
  int              nw;
  logic [CH_W-1:0] xs [MAXX];
  logic            xl [MAXX];
  int              nexp;
  logic            exp_done;
  logic            abort;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic build_expect(input logic [LIM_W-1:0] lim, input logic endf);
    int i = 0;
    logic stop = 1'b0;
    nexp = 0;
    while (i < nw && !stop) begin
      logic [WW-1:0] w = wbuf[i];
      logic [47:0]   run = 48'(1) + 48'(w[CH_W]);
      if (w[CH_W+1] && i + 1 < nw) begin
        run = run + 48'(wbuf[i+1]) * 2;
        i += 2;
      end else i += 1;
      while (run != 0 && !stop) begin
        if (lim != 0 && nexp == int'(lim)) stop = 1'b1;
        else begin
          xs[nexp] = w[CH_W-1:0];
          xl[nexp] = 1'b0;
          nexp++;
          run--;
        end
      end
    end
    exp_done = 1'b0;
    if (lim != 0 && nexp == int'(lim)) begin xl[nexp-1] = 1'b1; exp_done = 1'b1; end
    else if (endf && nexp > 0) begin xl[nexp-1] = 1'b1; exp_done = 1'b1; end
  endtask

  task automatic produce(input logic endf);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = wbuf[i];
      in_end   = endf && (i == nw - 1);
      while (!in_ready && !done && !abort) @(negedge clk);
      if (done || abort) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_end   = 1'b0;
  endtask

  task automatic consume(input int rp, input string req);
    int idx = 0, tmo = 0;
    logic overlap = 1'b0;
    while (idx < nexp && !abort) begin
      @(negedge clk);
      out_ready = (($urandom % 4) < rp);
      if (out_valid && in_ready) overlap = 1'b1;
      if (out_valid && out_ready) begin
        chk({req, " sample"}, 64'(out_sample), 64'(xs[idx]));
        chk({req, " last"},   64'(out_last),   64'(xl[idx]));
        idx++;
      end
      if (++tmo > 20000) begin
        abort = 1'b1;
        chk({req, " beats"}, 64'(idx), 64'(nexp));
      end
    end
    chk("R4 no in_ready while emitting", 64'(overlap), 64'd0);
  endtask

  task automatic do_clear;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic run_case(input logic [LIM_W-1:0] lim, input logic endf, input int rp,
                          input string req);
    int extra = 0;
    do_clear();
    limit = lim;
    abort = 1'b0;
    build_expect(lim, endf);
    fork
      produce(endf);
      consume(rp, req);
    join
    out_ready = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    chk({req, " no extra beats"}, 64'(extra), 64'd0);
    chk({req, " done"}, 64'(done), 64'(exp_done));
  endtask

  task automatic gen_random(input int n);
    int i = 0;
    while (i < n) begin
      logic [WW-1:0] w = {4'($urandom), 32'($urandom)};
      wbuf[i] = w;
      i++;
      if (w[CH_W+1]) begin
        if (i < n) begin wbuf[i] = WW'($urandom % 16); i++; end
        else wbuf[i-1][CH_W+1] = 1'b0;
      end
    end
    nw = n;
  endtask

  initial begin
    rst_n = 1'b0; clear = 1'b0; in_valid = 1'b0; in_end = 1'b0;
    in_word = '0; out_ready = 1'b0; limit = '0; abort = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready",  64'(in_ready),  64'd1);
    chk("R10 done",      64'(done),      64'd0);
    chk("R10 out_last",  64'(out_last),  64'd0);
    chk("R10 out_sample", 64'(out_sample), 64'd0);

    // R1 R2: single words, one and two samples
    wbuf[0] = {2'b00, 34'h2_1234_5678}; wbuf[1] = {2'b01, 34'h1_0F0F_0F0F};
    wbuf[2] = {2'b00, 34'h3_FFFF_FFFF}; nw = 3;
    run_case('0, 1'b1, 4, "R1 R2 plain runs");
    // R3: length words, with and without repeat bit, zero length
    wbuf[0] = {2'b10, 34'h0_AAAA_5555}; wbuf[1] = 36'd3;
    wbuf[2] = {2'b11, 34'h1_5555_AAAA}; wbuf[3] = 36'd0;
    wbuf[4] = {2'b11, 34'h2_0000_0001}; wbuf[5] = 36'd7;
    wbuf[6] = {2'b00, 34'h0_0000_00FF}; nw = 7;
    run_case('0, 1'b1, 2, "R3 length words");
    // R6 R7 R4: random runs, end marker, varied backpressure
    for (int s = 0; s < 8; s++) begin
      gen_random(40);
      run_case('0, 1'b1, 1 + (s % 4), "R7 random end");
    end
    // R6: no limit, no end marker: all samples, done stays low
    gen_random(30);
    run_case('0, 1'b0, 3, "R6 unlimited");
    chk("R6 in_ready after stream", 64'(in_ready), 64'd1);
    // R5: limit truncation mid-stream
    for (int s = 0; s < 8; s++) begin
      gen_random(40);
      run_case(LIM_W'(1 + ($urandom % 60)), 1'b1, 1 + (s % 4), "R5 limit");
    end
    // R5: limit equal to one
    wbuf[0] = {2'b11, 34'h1_2345_6789}; wbuf[1] = 36'd4; nw = 2;
    run_case(40'd1, 1'b0, 4, "R5 limit one");
    // R9: all-ones length word cut by a limit
    wbuf[0] = {2'b11, 34'h0_BEEF_CAFE}; wbuf[1] = {WW{1'b1}}; nw = 2;
    run_case(40'd50, 1'b0, 3, "R9 huge run");

    // R8: clear in the middle of a run
    do_clear();
    limit = '0;
    wbuf[0] = {2'b10, 34'h3_1111_2222}; wbuf[1] = 36'd100; nw = 2;
    produce(1'b0);
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    out_ready = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R8 out_valid after clear", 64'(out_valid), 64'd0);
    chk("R8 out_sample after clear", 64'(out_sample), 64'd0);
    chk("R8 in_ready after clear", 64'(in_ready), 64'd1);
    chk("R8 done after clear", 64'(done), 64'd0);
    // R8: sample count restarted (limit 3 must stop the next run)
    limit = 40'd3;
    abort = 1'b0;
    wbuf[0] = {2'b11, 34'h0_7777_8888}; wbuf[1] = 36'd5; nw = 2;
    build_expect(40'd3, 1'b0);
    fork
      produce(1'b0);
      consume(4, "R8 count restart");
    join
    repeat (3) @(negedge clk);
    chk("R8 count restart done", 64'(done), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule